// File: doc/BRIEF.md
# Raster Video Address Sequencer

This block produces the character-pointer and row addressing for a raster text and bitmap display engine. Every clock is one memory cycle of a raster line. An outside timing generator supplies the raster line number and the position of the cycle within the line (1 to 63). A comparator outside the block supplies the flag that marks a line on which character pointers must be fetched. The block keeps a 10-bit video counter, a 10-bit base copy of it, a 3-bit row counter and a 6-bit index into a 40-slot by 12-bit line buffer. It asks for the shared bus and stores the fetched pointer words. It replays those words one per graphics slot on every pixel row of the text row.

All counter updates happen at fixed cycle positions. The video counter is loaded from the base at the start of each line. It then advances once for each graphics slot while display state is held. The base copies the video counter back only when the row counter has reached its last value. The row counter is cleared only on fetch lines. As a result, which raster lines carry the fetch flag sets how addresses move through a frame. The address fetch unit downstream combines `vid_cnt`, `row_cnt` and `gfx_ptr` into memory addresses.

Top module: `vid_addr_seq`

## Requirements
- R1: While reset is held, `vid_cnt`, `vid_base`, `row_cnt`, `buf_idx` and `gfx_ptr` read 0, `disp_state` reads 0 (idle) and `bus_avail` reads 1.
- R2: During any cycle of raster line 0, `vid_base` is cleared, so it reads 0 from the next cycle. This takes priority over the load at cycle 58.
- R3: At cycle 14 the video counter takes the value of the base and the buffer index becomes 0. If `bad_line` is 1 in that cycle, the row counter also becomes 0.
- R4: `bus_avail` is 0 exactly in the cycles numbered 12 to 54 in which `bad_line` is 1. It is 1 from cycle 55 on, and in any cycle where `bad_line` is 0.
- R5: `ptr_fetch` is 1 in the cycles numbered 15 to 54 in which `bad_line` is 1. The `ptr_word` of such a cycle is stored in the buffer slot that `buf_idx` holds after that cycle.
- R6: A graphics step occurs in cycles 16 to 55 while display state is held or `bad_line` is 1. In that step the slot at `buf_idx` is copied to `gfx_ptr` for the next cycle, and `vid_cnt` and `buf_idx` each advance by one. `vid_cnt` wraps modulo 1024.
- R7: A cycle with `bad_line` at 1 leaves `disp_state` at 1 in the following cycle.
- R8: At cycle 58, if `row_cnt` is 7, `vid_base` takes `vid_cnt`, and the block goes idle unless `bad_line` is 1. If display state holds after this, `row_cnt` advances modulo 8 (7 goes to 0).
- R9: In idle state with `bad_line` at 0, `vid_cnt` and `buf_idx` do not change outside cycle 14.
- R10: Over a frame whose fetch lines are every eighth line from 0x33 to 0xF3, the video counter starts text row k at 40·k. The row counter runs 0 to 7 across the eight lines of each row, and the frame ends with a base of 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-cycle clock, one edge per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| raster_line | input | 9 | Current raster line number |
| line_cycle | input | 6 | Cycle position within the line, 1 to 63, binary |
| bad_line | input | 1 | Pointer-fetch line condition for this cycle |
| ptr_word | input | 12 | Pointer word on the data bus in this cycle |
| bus_avail | output | 1 | 0 requests the bus for pointer fetches |
| ptr_fetch | output | 1 | A pointer fetch is performed in this cycle |
| disp_state | output | 1 | 1 display state, 0 idle state |
| vid_cnt | output | 10 | Video counter |
| vid_base | output | 10 | Video counter base |
| row_cnt | output | 3 | Pixel row within the text row |
| buf_idx | output | 6 | Line-buffer index |
| gfx_ptr | output | 12 | Pointer word read by the last graphics step |

## Verification
A wrong base or a missed load shows on `vid_cnt` in the cycle right after cycle 14 of the next line. By the following text row it has grown into an address offset that repeats on every line. A row counter that clears or advances on the wrong line shows at cycle 15 as a pixel-row number that is off by one or more. It also leaves the block in display state one line too long, which shows as `vid_cnt` still moving on a line that should be idle. An error in the write or read index of the line buffer shows within one cycle on `gfx_ptr` as a word shifted by one slot. The bench tags each fetched word with its line and cycle to expose exactly that.

// File: rtl/vas_pkg.sv
package vas_pkg;

  // Per-cycle decoded timing strobes for one raster line position.
  typedef struct packed {
    logic frame_clr;  // base cleared on this line
    logic line_load;  // counter load / index clear slot
    logic ba_win;     // bus request window
    logic ptr_win;    // pointer fetch window
    logic gfx_win;    // graphics fetch window
    logic row_chk;    // end-of-row evaluation slot
  } vas_strobe_t;

endpackage

// File: rtl/vas_cycle_decode.sv
module vas_cycle_decode
  import vas_pkg::*;
#(
  parameter int RAS_W       = 9,
  parameter int CYC_W       = 6,
  parameter int C_LOAD      = 14,
  parameter int C_BA_FIRST  = 12,
  parameter int C_FETCH_END = 54,
  parameter int C_PTR_FIRST = 15,
  parameter int C_GFX_FIRST = 16,
  parameter int C_GFX_LAST  = 55,
  parameter int C_ROW_CHK   = 58
) (
  input  logic [RAS_W-1:0] raster_line,
  input  logic [CYC_W-1:0] line_cycle,
  output vas_strobe_t      stb
);

  always_comb begin
    stb           = '0;
    stb.frame_clr = (raster_line == '0);
    stb.line_load = (line_cycle == CYC_W'(C_LOAD));
    stb.ba_win    = (line_cycle >= CYC_W'(C_BA_FIRST))  && (line_cycle <= CYC_W'(C_FETCH_END));
    stb.ptr_win   = (line_cycle >= CYC_W'(C_PTR_FIRST)) && (line_cycle <= CYC_W'(C_FETCH_END));
    stb.gfx_win   = (line_cycle >= CYC_W'(C_GFX_FIRST)) && (line_cycle <= CYC_W'(C_GFX_LAST));
    stb.row_chk   = (line_cycle == CYC_W'(C_ROW_CHK));
  end

endmodule

// File: rtl/vas_line_buf.sv
module vas_line_buf #(
  parameter int DEPTH  = 40,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [DATA_W-1:0] slot_rd [DEPTH];
  logic              wr_ok;
  logic              rd_ok;
  logic [DATA_W-1:0] rd_data_n;
  logic [DATA_W-1:0] rd_data_q;

  assign wr_ok = wr_en && (wr_idx <= LAST_IDX);
  assign rd_ok = rd_en && (rd_idx <= LAST_IDX);

  // One register per slot, each with its own write enable.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              slot_we;
    logic [DATA_W-1:0] slot_q;
    assign slot_we = wr_ok && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q <= wr_data;
    end
    assign slot_rd[g] = slot_q;
  end

  always_comb begin
    rd_data_n = rd_data_q;
    if (rd_ok) rd_data_n = slot_rd[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_data_n;
  end

  assign rd_data = rd_data_q;

endmodule

// File: rtl/vas_addr_ctr.sv
module vas_addr_ctr
  import vas_pkg::*;
#(
  parameter int VC_W  = 10,
  parameter int RC_W  = 3,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vas_strobe_t      stb,
  input  logic             bad_line,
  output logic [VC_W-1:0]  vc,
  output logic [VC_W-1:0]  vcbase,
  output logic [RC_W-1:0]  rc,
  output logic [IDX_W-1:0] vmli,
  output logic             disp,
  output logic             gfx_step
);

  logic [VC_W-1:0]  vc_q, vc_n, vcbase_q, vcbase_n;
  logic [RC_W-1:0]  rc_q, rc_n;
  logic [IDX_W-1:0] vmli_q, vmli_n;
  logic             disp_q, disp_n;
  logic             vc_en, vcbase_en, rc_en, vmli_en;
  logic             rc_last;

  assign rc_last  = (rc_q == '1);
  assign gfx_step = stb.gfx_win && (disp_q || bad_line);

  // Next-state logic
  always_comb begin
    disp_n = disp_q || bad_line;
    if (stb.row_chk && rc_last && !bad_line) disp_n = 1'b0;

    vc_en  = stb.line_load || gfx_step;
    vc_n   = stb.line_load ? vcbase_q : VC_W'(vc_q + 1'b1);

    vmli_en = stb.line_load || gfx_step;
    vmli_n  = stb.line_load ? '0 : IDX_W'(vmli_q + 1'b1);

    rc_en = (stb.line_load && bad_line) || (stb.row_chk && disp_n);
    rc_n  = (stb.line_load && bad_line) ? '0 : RC_W'(rc_q + 1'b1);

    vcbase_en = stb.frame_clr || (stb.row_chk && rc_last);
    vcbase_n  = stb.frame_clr ? '0 : vc_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc_q     <= '0;
      vcbase_q <= '0;
      rc_q     <= '0;
      vmli_q   <= '0;
      disp_q   <= 1'b0;
    end else begin
      if (vc_en)     vc_q     <= vc_n;
      if (vcbase_en) vcbase_q <= vcbase_n;
      if (rc_en)     rc_q     <= rc_n;
      if (vmli_en)   vmli_q   <= vmli_n;
      disp_q <= disp_n;
    end
  end

  assign vc     = vc_q;
  assign vcbase = vcbase_q;
  assign rc     = rc_q;
  assign vmli   = vmli_q;
  assign disp   = disp_q;

endmodule

// File: rtl/vid_addr_seq.sv
module vid_addr_seq
  import vas_pkg::*;
#(
  parameter int RAS_W      = 9,
  parameter int CYC_W      = 6,
  parameter int VC_W       = 10,
  parameter int RC_W       = 3,
  parameter int IDX_W      = 6,
  parameter int DATA_W     = 12,
  parameter int LINE_CHARS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAS_W-1:0]  raster_line,
  input  logic [CYC_W-1:0]  line_cycle,
  input  logic              bad_line,
  input  logic [DATA_W-1:0] ptr_word,
  output logic              bus_avail,
  output logic              ptr_fetch,
  output logic              disp_state,
  output logic [VC_W-1:0]   vid_cnt,
  output logic [VC_W-1:0]   vid_base,
  output logic [RC_W-1:0]   row_cnt,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [DATA_W-1:0] gfx_ptr
);

  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  vas_strobe_t      stb;
  logic             gfx_step;
  logic [IDX_W-1:0] wr_idx;

  vas_cycle_decode #(
    .RAS_W (RAS_W),
    .CYC_W (CYC_W)
  ) u_decode (
    .raster_line (raster_line),
    .line_cycle  (line_cycle),
    .stb         (stb)
  );

  vas_addr_ctr #(
    .VC_W  (VC_W),
    .RC_W  (RC_W),
    .IDX_W (IDX_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .stb      (stb),
    .bad_line (bad_line),
    .vc       (vid_cnt),
    .vcbase   (vid_base),
    .rc       (row_cnt),
    .vmli     (buf_idx),
    .disp     (disp_state),
    .gfx_step (gfx_step)
  );

  assign bus_avail = !(bad_line && stb.ba_win);
  assign ptr_fetch = bad_line && stb.ptr_win;
  // The pointer write lands in the slot the index reaches after this cycle's step.
  assign wr_idx    = gfx_step ? IDX_W'(buf_idx + 1'b1) : buf_idx;

  vas_line_buf #(
    .DEPTH  (LINE_CHARS),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (ptr_fetch),
    .wr_idx  (wr_idx),
    .wr_data (ptr_word),
    .rd_en   (gfx_step),
    .rd_idx  (buf_idx),
    .rd_data (gfx_ptr)
  );

endmodule

// File: rtl/vas_chk.sv
module vas_chk #(
  parameter int RAS_W = 9,
  parameter int CYC_W = 6,
  parameter int VC_W  = 10,
  parameter int RC_W  = 3,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RAS_W-1:0] raster_line,
  input logic [CYC_W-1:0] line_cycle,
  input logic             bad_line,
  input logic             bus_avail,
  input logic             ptr_fetch,
  input logic             disp_state,
  input logic [VC_W-1:0]  vid_cnt,
  input logic [VC_W-1:0]  vid_base,
  input logic [RC_W-1:0]  row_cnt,
  input logic [IDX_W-1:0] buf_idx
);

  // R2
  base_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raster_line == '0) |=> (vid_base == '0));

  // R3
  line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cycle == CYC_W'(14)) |=> ((buf_idx == '0) && (vid_cnt == $past(vid_base))));

  // R3
  row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_cycle == CYC_W'(14)) && bad_line) |=> (row_cnt == '0));

  // R4
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cycle == CYC_W'(55)) |-> bus_avail);

  // R5
  fetch_holds_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_fetch |-> !bus_avail);

  // R6
  gfx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_cycle >= CYC_W'(16)) && (line_cycle <= CYC_W'(55)) && (disp_state || bad_line))
    |=> (vid_cnt == VC_W'($past(vid_cnt) + 1'b1)));

  // R7
  force_display_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_line |=> disp_state);

  // R8
  row_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_cycle == CYC_W'(58)) && (row_cnt == '1) && !bad_line && (raster_line != '0))
    |=> (!disp_state && (vid_base == $past(vid_cnt)) && (row_cnt == '1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_state && !bad_line && (line_cycle != CYC_W'(14)))
    |=> ($stable(vid_cnt) && $stable(buf_idx)));

endmodule

bind vid_addr_seq vas_chk #(
  .RAS_W (RAS_W),
  .CYC_W (CYC_W),
  .VC_W  (VC_W),
  .RC_W  (RC_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .raster_line (raster_line),
  .line_cycle  (line_cycle),
  .bad_line    (bad_line),
  .bus_avail   (bus_avail),
  .ptr_fetch   (ptr_fetch),
  .disp_state  (disp_state),
  .vid_cnt     (vid_cnt),
  .vid_base    (vid_base),
  .row_cnt     (row_cnt),
  .buf_idx     (buf_idx)
);

// File: tb/tb_vid_addr_seq.sv
`timescale 1ns/1ps
module tb_vid_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  raster_line;
  logic [5:0]  line_cycle;
  logic        bad_line;
  logic [11:0] ptr_word;
  logic        bus_avail, ptr_fetch, disp_state;
  logic [9:0]  vid_cnt, vid_base;
  logic [2:0]  row_cnt;
  logic [5:0]  buf_idx;
  logic [11:0] gfx_ptr;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  vid_addr_seq dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .raster_line (raster_line),
    .line_cycle  (line_cycle),
    .bad_line    (bad_line),
    .ptr_word    (ptr_word),
    .bus_avail   (bus_avail),
    .ptr_fetch   (ptr_fetch),
    .disp_state  (disp_state),
    .vid_cnt     (vid_cnt),
    .vid_base    (vid_base),
    .row_cnt     (row_cnt),
    .buf_idx     (buf_idx),
    .gfx_ptr     (gfx_ptr)
  );

  function automatic logic [11:0] pat(input int r, input int c);
    return {6'(r & 63), 6'(c & 63)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one memory cycle after the falling edge, then settle before sampling.
  task automatic step(input int r, input int c, input logic bl);
    @(negedge clk);
    raster_line = 9'(r);
    line_cycle  = 6'(c);
    bad_line    = bl;
    ptr_word    = pat(r, c);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(311, 1, 1'b0);
    step(311, 2, 1'b0);
    chk("R1 vid_cnt",  int'(vid_cnt), 0);
    chk("R1 vid_base", int'(vid_base), 0);
    chk("R1 row_cnt",  int'(row_cnt), 0);
    chk("R1 buf_idx",  int'(buf_idx), 0);
    chk("R1 gfx_ptr",  int'(gfx_ptr), 0);
    chk("R1 disp",     int'(disp_state), 0);
    chk("R1 bus",      int'(bus_avail), 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 3; c <= 63; c++) step(311, c, 1'b0);
  endtask

  task automatic t_frame();
    for (int r = 0; r <= 311; r++) begin
      logic bl;
      logic dl;
      int   sub;
      int   row;
      int   lastbad;
      int   gerr;
      bl      = (r >= 48) && (r <= 247) && ((r & 7) == 3);
      dl      = (r >= 51) && (r <= 250);
      sub     = (r - 51) & 7;
      row     = (r - 51) >>> 3;
      lastbad = r - sub;
      gerr    = 0;
      for (int c = 1; c <= 63; c++) begin
        step(r, c, bl);
        if (dl && c == 15) begin
          chk("R10 row start address", int'(vid_cnt), 40 * row);
          chk("R10 pixel row", int'(row_cnt), sub);
          if (bl) chk("R3 index cleared", int'(buf_idx), 0);
        end
        if (dl && c >= 17 && c <= 56 && gfx_ptr !== pat(lastbad, c - 2)) gerr++;
        if (dl && c == 63) chk("R6 index after 40 steps", int'(buf_idx), 40);
        if (bl) begin
          if (c == 11) chk("R4 bus before window", int'(bus_avail), 1);
          if (c == 12) chk("R4 bus first request", int'(bus_avail), 0);
          if (c == 54) chk("R4 bus last request", int'(bus_avail), 0);
          if (c == 55) chk("R4 bus released", int'(bus_avail), 1);
          if (c == 14) chk("R5 no fetch before 15", int'(ptr_fetch), 0);
          if (c == 15) chk("R5 first fetch", int'(ptr_fetch), 1);
          if (c == 55) chk("R5 fetch ended", int'(ptr_fetch), 0);
        end
        if (r == 50 && c == 20) chk("R7 idle before first row", int'(disp_state), 0);
        if (r == 51 && c == 2)  chk("R7 display forced", int'(disp_state), 1);
        if (r == 251 && c == 15) begin
          chk("R8 base after last row", int'(vid_base), 1000);
          chk("R8 idle after row 7", int'(disp_state), 0);
          chk("R8 row held at 7", int'(row_cnt), 7);
          chk("R10 final address", int'(vid_cnt), 1000);
        end
        if (r == 251 && c == 60) begin
          chk("R9 vid_cnt held idle", int'(vid_cnt), 1000);
          chk("R9 buf_idx held idle", int'(buf_idx), 0);
        end
      end
      if (dl) chk("R6 replayed pointer words", gerr, 0);
    end
  endtask

  // Fetch flag raised mid-line on a line that started idle with row_cnt = 7.
  task automatic t_late_bad();
    for (int c = 1; c <= 63; c++) begin
      logic bl;
      bl = (c >= 20) && (c <= 60);
      step(300, c, bl);
      if (c == 19) chk("R4 bus before flag", int'(bus_avail), 1);
      if (c == 20) begin
        chk("R4 bus on late flag", int'(bus_avail), 0);
        chk("R5 fetch on late flag", int'(ptr_fetch), 1);
        chk("R7 display not yet", int'(disp_state), 0);
      end
      if (c == 21) chk("R7 display forced late", int'(disp_state), 1);
      if (c == 55) chk("R4 bus released at 55", int'(bus_avail), 1);
      if (c == 57) chk("R6 vid_cnt wraps", int'(vid_cnt), 12);
      if (c == 58) chk("R8 row at 7 before check", int'(row_cnt), 7);
      if (c == 59) begin
        chk("R8 row wraps to 0", int'(row_cnt), 0);
        chk("R8 base loaded", int'(vid_base), 12);
        chk("R8 display kept", int'(disp_state), 1);
      end
    end
  endtask

  task automatic t_frame_clear();
    step(0, 1, 1'b0);
    chk("R2 base before clear", int'(vid_base), 12);
    step(0, 2, 1'b0);
    chk("R2 base cleared", int'(vid_base), 0);
    step(0, 3, 1'b0);
    chk("R2 base stays clear", int'(vid_base), 0);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    raster_line = '0;
    line_cycle  = 6'd1;
    bad_line    = 1'b0;
    ptr_word    = '0;
    t_reset();
    t_frame();
    t_late_bad();
    t_frame_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule